// File: doc/BRIEF.md
# Sync-Gated Receive Bit FIFO

This block sits on the receive data path between a bit-recovery stage and a host interface. Each recovered bit arrives with a one-cycle strobe. While armed, the block hunts for a start pattern. The pattern is either two bytes, a fixed high byte 2Dh followed by a programmable low byte, or the programmable low byte alone. Once the pattern has been seen, or right away when the host asks to fill unconditionally, every strobed bit goes into a 16-bit store. The store packs bits into bytes, with the first bit received becoming the most significant bit of its byte.

The host takes whole bytes out with a read request. A level interrupt tells the host when the number of bits held has reached a programmable 4-bit threshold. Empty and sticky overflow flags report the state of the store. Each packet has to be framed by the host: dropping the fill enable flushes the store, clears overflow and re-arms the pattern hunt.

Top module: `sync_rx_fifo`

## Requirements
- R1: After reset the block reports empty (`fifo_empty`=1), no interrupt, no overflow, and `rd_data`=0.
- R2: With `two_byte_sync`=1 and `fill_always`=0, no bit is stored until the last 16 strobed bits, oldest first, equal {2Dh, `sync_lo`}. The pattern bits are not stored, and every bit after the match is stored.
- R3: With `two_byte_sync`=0 and `fill_always`=0, filling starts after the last 8 strobed bits equal `sync_lo`, for any of the 256 values of `sync_lo`. The pattern bits are not stored.
- R4: A match counts only bits strobed since the fill enable last rose. Bits left over from an earlier packet, or a partial pattern, never open the gate.
- R5: With `fill_always`=1, every bit strobed while `fill_en`=1 is stored, starting with the first strobe.
- R6: The first stored bit becomes bit 7 of the first byte read. Bytes are read back in arrival order.
- R7: While `fill_en`=0, strobed bits are ignored. One cycle after `fill_en` is low, the store is empty and overflow is clear.
- R8: `fifo_irq` is high exactly when the number of held bits is at least `irq_lvl`. An `irq_lvl` of 0 acts as 1, so the interrupt is never raised on an empty store.
- R9: The store holds 16 bits. A bit strobed while 16 bits are held is dropped and sets `fifo_ovf`, even if a read pops a byte in that same cycle. `fifo_ovf` stays set until `fill_en` goes low.
- R10: A read request while fewer than 8 bits are held returns 0 on `rd_data` and removes nothing.
- R11: `rd_data` changes only in the cycle after a read request and otherwise holds its value.
- R12: `fifo_empty` is high exactly when no bits are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Recovered data bit |
| bit_stb | input | 1 | One-cycle strobe qualifying `bit_in` |
| fill_en | input | 1 | Fill enable; low flushes the store and re-arms the hunt |
| fill_always | input | 1 | 1: fill without a pattern; 0: fill after the pattern |
| two_byte_sync | input | 1 | 1: pattern is {2Dh, `sync_lo`}; 0: pattern is `sync_lo` |
| sync_lo | input | 8 | Programmable low pattern byte |
| irq_lvl | input | 4 | Interrupt threshold in bits |
| rd_req | input | 1 | Pop one byte |
| rd_data | output | 8 | Byte returned by the last read request |
| fifo_irq | output | 1 | Fill level reached |
| fifo_empty | output | 1 | No bits held |
| fifo_ovf | output | 1 | Sticky overflow |

## Verification
The hardest case to reach from the ports is a pattern that would match only if register contents from before arming were counted. The bench reaches it by arming and then sending just the trailing 14 bits of the two-byte pattern. It does the same in one-byte mode with a pattern of 00h followed by seven zeros. A second awkward case is a read while only part of a byte is held. The bench stops after 5 bits, issues a read, then completes the byte and reads again. The interrupt threshold is swept over all 16 values against every fill level from 0 to 16 bits. The one-byte pattern is swept over all 256 values.

// File: rtl/rxf_pkg.sv
// Shared definitions for the sync-gated receive FIFO.
package rxf_pkg;
    // Fixed upper pattern byte used in two-byte mode.
    localparam logic [7:0] RXF_SYNC_HI_DEFAULT = 8'h2D;

    // Fill gate: hunting for the pattern, or passing bits to the store.
    typedef enum logic {
        GATE_HUNT = 1'b0,
        GATE_FILL = 1'b1
    } gate_e;
endpackage

// File: rtl/rxf_sync_gate.sv
// Pattern hunter and fill gate.
// Shifts every strobed bit into a 2*BYTE_W history while hunting. The gate
// opens on the strobe that completes the pattern; that bit is not passed on.
// A seen-bit counter makes sure that only bits strobed since arming can
// form a match. Assumes fill_en low means flush/re-arm.
module rxf_sync_gate
    import rxf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] SYNC_HI = RXF_SYNC_HI_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic              fill_always,
    input  logic              two_byte,
    input  logic [BYTE_W-1:0] pattern_lo,
    input  logic              bit_in,
    input  logic              bit_stb,
    output logic              store_stb,
    output logic              store_bit
);
    localparam int HIST_W = 2 * BYTE_W;
    localparam int SEEN_W = $clog2(HIST_W + 1);
    localparam logic [SEEN_W-1:0] SEEN_MAX = SEEN_W'(HIST_W);
    localparam logic [SEEN_W-1:0] NEED_ONE = SEEN_W'(BYTE_W - 1);
    localparam logic [SEEN_W-1:0] NEED_TWO = SEEN_W'(HIST_W - 1);

    gate_e              gate_q;
    logic [HIST_W-1:0]  hist_q;
    logic [SEEN_W-1:0]  seen_q;
    logic [HIST_W-1:0]  hist_nx;
    logic               hunting;
    logic               hit;

    // Candidate history including the bit on the input now.
    always_comb hist_nx = {hist_q[HIST_W-2:0], bit_in};

    // Pattern compare for the selected length, qualified by bits seen.
    always_comb begin
        if (two_byte)
            hit = (hist_nx == {SYNC_HI, pattern_lo}) && (seen_q >= NEED_TWO);
        else
            hit = (hist_nx[BYTE_W-1:0] == pattern_lo) && (seen_q >= NEED_ONE);
    end

    always_comb hunting = fill_en && !fill_always && (gate_q == GATE_HUNT);

    // Gate state, history and seen counter; fill_en low re-arms.
    always_ff @(posedge clk) begin
        if (!rst_n || !fill_en) begin
            gate_q <= GATE_HUNT;
            hist_q <= '0;
            seen_q <= '0;
        end else if (hunting && bit_stb) begin
            hist_q <= hist_nx;
            if (seen_q != SEEN_MAX) seen_q <= seen_q + 1'b1;
            if (hit) gate_q <= GATE_FILL;
        end
    end

    // Bits reach the store once the gate is open or when filling always.
    always_comb begin
        store_stb = fill_en && bit_stb && ((gate_q == GATE_FILL) || fill_always);
        store_bit = bit_in;
    end

    // R4
    early_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_q == GATE_FILL) && two_byte) |-> ($past(seen_q) >= NEED_TWO));

    // R7
    rearm_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> (gate_q == GATE_HUNT));
endmodule

// File: rtl/rxf_bit_store.sv
// Bit-granular store packed into bytes.
// Writes one bit per write strobe, first bit at the byte's MSB. Reads pop a
// whole byte. Assumes DEPTH is a power of two holding at least two bytes.
// A read with less than one byte held returns zero. A write to a full store
// is dropped and raises a sticky overflow.
module rxf_bit_store #(
    parameter int DEPTH  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         wr_stb,
    input  logic                         wr_bit,
    input  logic                         rd_req,
    output logic [BYTE_W-1:0]            rd_data,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         overflow
);
    localparam int NBYTES = DEPTH / BYTE_W;
    localparam int PTR_W  = $clog2(DEPTH);
    localparam int BIDX_W = $clog2(BYTE_W);
    localparam int RB_W   = $clog2(NBYTES);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0]  FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]  BYTE_CNT = CNT_W'(BYTE_W);
    localparam logic [BIDX_W-1:0] LAST_BIT = BIDX_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] mem [NBYTES];
    logic [PTR_W-1:0]  wptr_q;
    logic [RB_W-1:0]   rbyte_q;
    logic [CNT_W-1:0]  count_q;
    logic              full, can_rd, do_wr, do_rd;
    logic [RB_W-1:0]   wbyte;
    logic [BIDX_W-1:0] wbit;

    // Store conditions taken from the level before this cycle's update.
    always_comb begin
        full   = (count_q == FULL_CNT);
        can_rd = (count_q >= BYTE_CNT);
        do_wr  = wr_stb && !full && !flush;
        do_rd  = rd_req && can_rd && !flush;
        wbyte  = wptr_q[PTR_W-1:BIDX_W];
        wbit   = wptr_q[BIDX_W-1:0];
    end

    // Bit write into the addressed byte, MSB first.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wbyte][LAST_BIT - wbit] <= wr_bit;
    end

    // Pointers, level and overflow; flush empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr_q   <= '0;
            rbyte_q  <= '0;
            count_q  <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr) wptr_q <= wptr_q + 1'b1;
            if (do_rd) rbyte_q <= rbyte_q + 1'b1;
            count_q <= count_q + CNT_W'(do_wr) - (do_rd ? BYTE_CNT : '0);
            if (wr_stb && full) overflow <= 1'b1;
        end
    end

    // Read data register, updated only by a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= do_rd ? mem[rbyte_q] : '0;
    end

    always_comb level = count_q;

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_stb && !rd_req && !flush) |=> (count_q == FULL_CNT) && overflow);

    // R10
    short_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !can_rd && !flush) |=> (rd_data == '0) && $stable(count_q));

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));
endmodule

// File: rtl/sync_rx_fifo.sv
// Sync-gated receive FIFO top.
// Joins the pattern gate to the bit store and derives the level interrupt
// and empty flag. Configuration inputs are assumed steady within a packet;
// fill_en low flushes and re-arms.
module sync_rx_fifo
    import rxf_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DEPTH  = 16,
    parameter int LVL_W  = 4,
    parameter logic [BYTE_W-1:0] SYNC_HI = RXF_SYNC_HI_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_stb,
    input  logic              fill_en,
    input  logic              fill_always,
    input  logic              two_byte_sync,
    input  logic [BYTE_W-1:0] sync_lo,
    input  logic [LVL_W-1:0]  irq_lvl,
    input  logic              rd_req,
    output logic [BYTE_W-1:0] rd_data,
    output logic              fifo_irq,
    output logic              fifo_empty,
    output logic              fifo_ovf
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             st_stb, st_bit;
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] lvl_eff;

    rxf_sync_gate #(.BYTE_W(BYTE_W), .SYNC_HI(SYNC_HI)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_en),
        .fill_always(fill_always),
        .two_byte   (two_byte_sync),
        .pattern_lo (sync_lo),
        .bit_in     (bit_in),
        .bit_stb    (bit_stb),
        .store_stb  (st_stb),
        .store_bit  (st_bit)
    );

    rxf_bit_store #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (!fill_en),
        .wr_stb   (st_stb),
        .wr_bit   (st_bit),
        .rd_req   (rd_req),
        .rd_data  (rd_data),
        .level    (level),
        .overflow (fifo_ovf)
    );

    // Threshold of zero behaves as one so an empty store never interrupts.
    always_comb lvl_eff = (irq_lvl == '0) ? CNT_W'(1) : CNT_W'(irq_lvl);

    // Status outputs derived from the held bit count.
    always_comb begin
        fifo_irq   = (level >= lvl_eff);
        fifo_empty = (level == '0);
    end

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_en |=> (fifo_empty && !fifo_ovf));

    // R8
    irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_irq |-> !fifo_empty);

    // R2
    hunt_nostore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en) |=> (fill_en && !fill_always && !bit_stb && !rd_req) |=> fifo_empty);
endmodule

// File: tb/sync_rx_fifo_bench.sv
module sync_rx_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0, bit_stb = 1'b0, fill_en = 1'b0;
    logic       fill_always = 1'b0, two_byte_sync = 1'b0, rd_req = 1'b0;
    logic [7:0] sync_lo = 8'hD4;
    logic [3:0] irq_lvl = 4'd0;
    logic [7:0] rd_data;
    logic       fifo_irq, fifo_empty, fifo_ovf;
    int         n_cmp = 0, n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    sync_rx_fifo u_sync_rx_fifo (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_stb(bit_stb),
        .fill_en(fill_en), .fill_always(fill_always), .two_byte_sync(two_byte_sync),
        .sync_lo(sync_lo), .irq_lvl(irq_lvl), .rd_req(rd_req), .rd_data(rd_data),
        .fifo_irq(fifo_irq), .fifo_empty(fifo_empty), .fifo_ovf(fifo_ovf)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_in = b; bit_stb = 1'b1;
        @(negedge clk); bit_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic rd();
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk); fill_en = 1'b0;
        @(negedge clk); fill_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", fifo_empty, 1);
        chk("R1 irq", fifo_irq, 0);
        chk("R1 ovf", fifo_ovf, 0);
        chk("R1 rd_data", rd_data, 0);

        // R8 R5 R12 threshold sweep with unconditional fill
        fill_always = 1'b1;
        for (int lvl = 0; lvl < 16; lvl++) begin
            irq_lvl = 4'(lvl);
            arm();
            chk("R12 empty after arm", fifo_empty, 1);
            chk("R8 irq at zero", fifo_irq, 0);
            for (int n = 1; n <= 16; n++) begin
                send_bit(n[0]);
                chk("R8 irq level", fifo_irq, (n >= ((lvl == 0) ? 1 : lvl)) ? 1 : 0);
                chk("R12 not empty", fifo_empty, 0);
            end
            chk("R9 no ovf at 16", fifo_ovf, 0);
        end

        // R7 strobes while disabled are ignored
        @(negedge clk); fill_en = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        @(negedge clk); fill_en = 1'b1;
        @(negedge clk);
        chk("R7 ignored while low", fifo_empty, 1);

        // R9 overflow
        irq_lvl = 4'd15;
        arm();
        send_byte(8'hC3); send_byte(8'h96);
        chk("R9 no ovf yet", fifo_ovf, 0);
        send_bit(1'b1);
        chk("R9 ovf set", fifo_ovf, 1);
        rd(); chk("R6 first byte", rd_data, 8'hC3);
        rd(); chk("R9 dropped bit", rd_data, 8'h96);
        chk("R12 empty after drain", fifo_empty, 1);
        chk("R9 ovf sticky", fifo_ovf, 1);
        arm();
        chk("R7 ovf cleared", fifo_ovf, 0);

        // R10 partial byte read, R11 hold
        send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
        rd();
        chk("R10 short read zero", rd_data, 0);
        chk("R10 nothing removed", fifo_empty, 0);
        send_bit(0); send_bit(1); send_bit(1);
        rd();
        chk("R10 R6 completed byte", rd_data, 8'hB3);
        chk("R12 empty", fifo_empty, 1);
        repeat (3) @(negedge clk);
        chk("R11 rd_data holds", rd_data, 8'hB3);
        rd();
        chk("R10 empty read zero", rd_data, 0);

        // R3 one-byte pattern sweep
        fill_always = 1'b0; two_byte_sync = 1'b0;
        for (int p = 0; p < 256; p++) begin
            logic [7:0] d;
            d = 8'((p * 7 + 3) & 255);
            sync_lo = 8'(p);
            arm();
            send_byte(8'(p));
            chk("R3 pattern not stored", fifo_empty, 1);
            send_byte(d);
            rd();
            chk("R3 data after pattern", rd_data, {8'h0, d});
            chk("R3 drained", fifo_empty, 1);
        end

        // R4 one-byte: partial pattern after arming
        sync_lo = 8'h00;
        arm();
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        chk("R4 seven zeros", fifo_empty, 1);
        send_bit(1'b1);
        chk("R4 no match", fifo_empty, 1);
        send_byte(8'h00);
        chk("R3 match not stored", fifo_empty, 1);
        send_byte(8'h81);
        rd();
        chk("R3 byte after zero pattern", rd_data, 8'h81);

        // R2 two-byte pattern
        two_byte_sync = 1'b1; sync_lo = 8'hD4;
        arm();
        send_byte(8'hD4);
        chk("R2 low byte alone", fifo_empty, 1);
        send_byte(8'h2D); send_byte(8'hD4);
        chk("R2 pattern not stored", fifo_empty, 1);
        send_byte(8'hA5); send_byte(8'h3C);
        rd(); chk("R2 R6 first", rd_data, 8'hA5);
        rd(); chk("R2 R6 second", rd_data, 8'h3C);
        chk("R12 drained", fifo_empty, 1);

        // R4 two-byte: only trailing 14 pattern bits after arming
        pat = 16'h2DD4;
        arm();
        for (int i = 13; i >= 0; i--) send_bit(pat[i]);
        send_byte(8'hFF);
        chk("R4 truncated pattern", fifo_empty, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule